// File: doc/BRIEF.md
# RTC Alarm Match and Interrupt Flag Unit

This unit sits beside the timekeeping core of a real-time clock. On every update-ended strobe it checks the current seconds, minutes and hours against three alarm bytes. It also keeps three sticky event flags: periodic, alarm and update-ended. A flag is enabled to interrupt only when its enable bit is set. Any enabled pending flag drives a summary bit and an active-low interrupt line.

Software services the interrupt by reading the flag byte. The read strobe returns the flags and then clears them. An event that lands in the same cycle as that read survives the clear, so no event is lost. An alarm byte whose two most significant bits are both one acts as a "don't care" and matches every value of its field. This allows alarms that repeat every second, minute or hour.

Top module: `rtc_irq_flags`

## Requirements
- R1: While reset is low and in the first cycle after it, `flag_byte` is 0x00 and `irq_n` is 1.
- R2: When `upd_done` is high at a clock edge, `flag_byte` bit 4 (update-ended flag) is 1 after that edge.
- R3: When `per_tick` is high at a clock edge, `flag_byte` bit 6 (periodic flag) is 1 after that edge.
- R4: When `upd_done` is high at an edge and every time field matches its alarm byte, `flag_byte` bit 5 (alarm flag) is 1 after that edge.
- R5: An alarm byte at 0xC0 or above (bits 7 and 6 both one) matches any value of its time field. Any other alarm byte matches only an equal value.
- R6: The alarm match is evaluated only at an `upd_done` edge. At any edge with neither `upd_done` nor `flag_rd` high, bit 5 keeps its value, whatever the time and alarm inputs do.
- R7: After each edge, bit 7 equals the OR over the three sources of (flag after that edge AND enable sampled at that edge). `ctrl_en` bit 2 enables periodic, bit 1 enables alarm and bit 0 enables update-ended.
- R8: During a cycle with `flag_rd` high, `flag_byte` shows the unmodified flags. After the edge, flags 6 to 4 are cleared unless an event sets them in that same cycle.
- R9: A `per_tick` or `upd_done` event sampled at the same edge as `flag_rd` sets its flag after the clear.
- R10: Bits 3 to 0 of `flag_byte` are always 0.
- R11: `irq_n` is the inverse of bit 7. Once low, it stays low until a read, unless the enables change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_sec | input | 8 | Current seconds value |
| cur_min | input | 8 | Current minutes value |
| cur_hour | input | 8 | Current hours value |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hour | input | 8 | Hours alarm byte |
| upd_done | input | 1 | One-cycle update-ended strobe |
| per_tick | input | 1 | One-cycle periodic event strobe |
| ctrl_en | input | 3 | Enables {periodic, alarm, update-ended} |
| flag_rd | input | 1 | Read strobe for the flag byte (clears on the edge) |
| flag_byte | output | 8 | Registered flag byte {irq, pf, af, uf, 0000} |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Every result in this block is due exactly one clock edge after the inputs that cause it. The flags, the summary bit and `irq_n` all come straight from one register stage. The bench drives inputs on the falling edge and lets one rising edge pass. Its behavioural model advances on that same rising edge, and the bench compares every output bit on the next falling edge. Directed checks follow the same rule. The value during a read is sampled before the clearing edge, and the cleared value or the kept event is sampled one edge later.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
    localparam int BYTE_W   = 8;
    localparam int FIELD_N  = 3;
    localparam int SRC_N    = 3;
    localparam int WILD_W   = 2;
    // flag byte layout: software decodes these positions
    localparam int IRQ_BIT  = 7;
    localparam int PF_BIT   = 6;
    localparam int AF_BIT   = 5;
    localparam int UF_BIT   = 4;
    // source index order inside ctrl_en / source vectors
    localparam int SRC_PF   = 2;
    localparam int SRC_AF   = 1;
    localparam int SRC_UF   = 0;

    typedef struct packed {
        logic irq;
        logic pf;
        logic af;
        logic uf;
    } flag_state_t;
endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
    parameter int W = 8,
    parameter int N = 3,
    parameter int WILD_W = 2
) (
    input  logic [N-1:0][W-1:0] cur,
    input  logic [N-1:0][W-1:0] alm,
    output logic [N-1:0]        field_hit,
    output logic                all_hit
);
    localparam int WILD_LO = W - WILD_W;

    for (genvar i = 0; i < N; i++) begin : g_field
        logic wild;
        logic equal;
        always_comb begin
            wild         = &alm[i][W-1:WILD_LO];
            equal        = (alm[i] == cur[i]);
            field_hit[i] = wild | equal;
        end
    end

    assign all_hit = &field_hit;
endmodule

// File: rtl/rtc_irq_qual.sv
module rtc_irq_qual #(
    parameter int N = 3
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] en,
    output logic         pending
);
    logic [N-1:0] masked;

    for (genvar s = 0; s < N; s++) begin : g_src
        assign masked[s] = flags[s] & en[s];
    end

    assign pending = |masked;
endmodule

// File: rtl/rtc_flag_reg.sv
module rtc_flag_reg
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  set_src,
    input  logic [SRC_N-1:0]  en,
    input  logic              clr,
    output flag_state_t       st_q
);
    flag_state_t st_d;
    logic [SRC_N-1:0] flags_d;
    logic pend_d;

    always_comb begin
        flags_d[SRC_PF] = set_src[SRC_PF] | (st_q.pf & ~clr);
        flags_d[SRC_AF] = set_src[SRC_AF] | (st_q.af & ~clr);
        flags_d[SRC_UF] = set_src[SRC_UF] | (st_q.uf & ~clr);
    end

    rtc_irq_qual #(.N(SRC_N)) i_qual (
        .flags   (flags_d),
        .en      (en),
        .pending (pend_d)
    );

    always_comb begin
        st_d     = st_q;
        st_d.pf  = flags_d[SRC_PF];
        st_d.af  = flags_d[SRC_AF];
        st_d.uf  = flags_d[SRC_UF];
        st_d.irq = pend_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: a read with no new events empties every flag
    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set_src == '0) |=> (st_q.pf == 1'b0 && st_q.af == 1'b0 && st_q.uf == 1'b0));

    // R9: an event coinciding with a read survives
    assert_event_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set_src[SRC_PF]) |=> st_q.pf);

    // R7: a pending enabled flag with stable enables keeps the summary bit
    assert_summary_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && !clr && $stable(en)) |=> st_q.irq);
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
    import rtc_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  cur_sec,
    input  logic [7:0]  cur_min,
    input  logic [7:0]  cur_hour,
    input  logic [7:0]  alm_sec,
    input  logic [7:0]  alm_min,
    input  logic [7:0]  alm_hour,
    input  logic        upd_done,
    input  logic        per_tick,
    input  logic [2:0]  ctrl_en,
    input  logic        flag_rd,
    output logic [7:0]  flag_byte,
    output logic        irq_n
);
    logic [FIELD_N-1:0][BYTE_W-1:0] cur_vec;
    logic [FIELD_N-1:0][BYTE_W-1:0] alm_vec;
    logic [FIELD_N-1:0]             field_hit;
    logic                           all_hit;
    logic [SRC_N-1:0]               set_src;
    flag_state_t                    st_q;

    assign cur_vec = {cur_hour, cur_min, cur_sec};
    assign alm_vec = {alm_hour, alm_min, alm_sec};

    rtc_alarm_cmp #(.W(BYTE_W), .N(FIELD_N), .WILD_W(WILD_W)) i_cmp (
        .cur       (cur_vec),
        .alm       (alm_vec),
        .field_hit (field_hit),
        .all_hit   (all_hit)
    );

    always_comb begin
        set_src         = '0;
        set_src[SRC_PF] = per_tick;
        set_src[SRC_AF] = upd_done & all_hit;
        set_src[SRC_UF] = upd_done;
    end

    rtc_flag_reg i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_src (set_src),
        .en      (ctrl_en),
        .clr     (flag_rd),
        .st_q    (st_q)
    );

    always_comb begin
        flag_byte          = '0;
        flag_byte[IRQ_BIT] = st_q.irq;
        flag_byte[PF_BIT]  = st_q.pf;
        flag_byte[AF_BIT]  = st_q.af;
        flag_byte[UF_BIT]  = st_q.uf;
        irq_n              = ~st_q.irq;
    end

    assert_update_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> flag_byte[4]);

    assert_periodic_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        per_tick |=> flag_byte[6]);

    assert_all_wild_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_done && alm_sec[7:6] == 2'b11 && alm_min[7:6] == 2'b11 && alm_hour[7:6] == 2'b11)
        |=> flag_byte[5]);

    assert_alarm_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_done && !flag_rd) |=> (flag_byte[5] == $past(flag_byte[5])));

    assert_low_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_byte[3:0] == 4'h0);

    assert_irq_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !flag_rd && $stable(ctrl_en)) |=> !irq_n);
endmodule

// File: tb/test_rtc_irq_flags.sv
module test_rtc_irq_flags;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hour = 8'h00;
    logic [7:0] alm_sec = 8'h00, alm_min = 8'h00, alm_hour = 8'h00;
    logic upd_done = 1'b0, per_tick = 1'b0, flag_rd = 1'b0;
    logic [2:0] ctrl_en = 3'b000;
    logic [7:0] flag_byte;
    logic irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 0;

    // reference state
    bit m_pf = 0, m_af = 0, m_uf = 0, m_irq = 0;

    always #2.5 clk = ~clk;

    rtc_irq_flags i_rtc_irq_flags (
        .clk(clk), .rst_n(rst_n),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
        .upd_done(upd_done), .per_tick(per_tick), .ctrl_en(ctrl_en),
        .flag_rd(flag_rd), .flag_byte(flag_byte), .irq_n(irq_n)
    );

    function automatic bit field_ok(input logic [7:0] a, input logic [7:0] c);
        return (a >= 8'hC0) || (a == c);
    endfunction

    always @(posedge clk) begin
        bit hit;
        if (!rst_n) begin
            m_pf = 0; m_af = 0; m_uf = 0; m_irq = 0;
        end else begin
            hit = field_ok(alm_sec, cur_sec) && field_ok(alm_min, cur_min) &&
                  field_ok(alm_hour, cur_hour);
            if (per_tick) m_pf = 1; else if (flag_rd) m_pf = 0;
            if (upd_done && hit) m_af = 1; else if (flag_rd) m_af = 0;
            if (upd_done) m_uf = 1; else if (flag_rd) m_uf = 0;
            m_irq = (m_pf && ctrl_en[2]) || (m_af && ctrl_en[1]) || (m_uf && ctrl_en[0]);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(flag_byte[6] == m_pf,  "R3 periodic flag",  flag_byte[6], m_pf);
            check(flag_byte[5] == m_af,  "R4 alarm flag",     flag_byte[5], m_af);
            check(flag_byte[4] == m_uf,  "R2 update flag",    flag_byte[4], m_uf);
            check(flag_byte[7] == m_irq, "R7 summary bit",    flag_byte[7], m_irq);
            check(flag_byte[3:0] == 4'h0, "R10 low nibble",   flag_byte[3:0], 0);
            check(irq_n == !m_irq,       "R11 irq pin",       irq_n, !m_irq);
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_strobes();
        upd_done = 0; per_tick = 0; flag_rd = 0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !finished) begin
                n_cmp++; n_bad++;
                $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        step(); step();
        check(flag_byte == 8'h00, "R1 flags in reset", flag_byte, 8'h00);
        check(irq_n == 1'b1, "R1 irq in reset", irq_n, 1);
        rst_n = 1; step();
        check(flag_byte == 8'h00 && irq_n, "R1 after reset", flag_byte, 8'h00);

        // update with no alarm match, nothing enabled
        cur_hour = 8'h12; cur_min = 8'h34; cur_sec = 8'h56;
        alm_hour = 8'h01; alm_min = 8'h02; alm_sec = 8'h03;
        upd_done = 1; step(); clear_strobes();
        check(flag_byte == 8'h10, "R2 update-ended flag", flag_byte, 8'h10);
        check(irq_n == 1'b1, "R7 no enable no irq", irq_n, 1);

        // read: shows value during read, cleared after
        flag_rd = 1;
        check(flag_byte == 8'h10, "R8 value during read", flag_byte, 8'h10);
        step(); clear_strobes();
        check(flag_byte == 8'h00, "R8 cleared after read", flag_byte, 8'h00);

        // periodic with its enable
        ctrl_en = 3'b100; per_tick = 1; step(); clear_strobes();
        check(flag_byte == 8'hC0, "R3 periodic with enable", flag_byte, 8'hC0);
        check(irq_n == 1'b0, "R11 irq asserted", irq_n, 0);
        repeat (4) step();
        check(irq_n == 1'b0, "R11 irq held until read", irq_n, 0);
        flag_rd = 1; step(); clear_strobes();
        check(flag_byte == 8'h00 && irq_n, "R8 read releases irq", flag_byte, 8'h00);

        // exact alarm match
        alm_hour = 8'h12; alm_min = 8'h34; alm_sec = 8'h56;
        ctrl_en = 3'b010; upd_done = 1; step(); clear_strobes();
        check(flag_byte == 8'hB0, "R4 exact alarm match", flag_byte, 8'hB0);
        flag_rd = 1; step(); clear_strobes();

        // matching inputs without update do not set alarm
        repeat (3) step();
        check(flag_byte[5] == 1'b0, "R6 no compare between updates", flag_byte[5], 0);

        // wildcards on seconds and minutes
        alm_sec = 8'hC0; alm_min = 8'hFF; cur_sec = 8'h57; cur_min = 8'h35;
        upd_done = 1; step(); clear_strobes();
        check(flag_byte[5] == 1'b1, "R5 wildcard match", flag_byte[5], 1);
        flag_rd = 1; step(); clear_strobes();

        // 0x80 is not a wildcard
        alm_sec = 8'h80; upd_done = 1; step(); clear_strobes();
        check(flag_byte[5] == 1'b0, "R5 single top bit not wild", flag_byte[5], 0);
        flag_rd = 1; step(); clear_strobes();

        // hour mismatch with wildcards elsewhere
        alm_sec = 8'hC0; alm_hour = 8'h11; upd_done = 1; step(); clear_strobes();
        check(flag_byte[5] == 1'b0, "R4 hour mismatch", flag_byte[5], 0);

        // event in the same cycle as a read
        flag_rd = 1; per_tick = 1; ctrl_en = 3'b000; step(); clear_strobes();
        check(flag_byte == 8'h40, "R9 periodic kept over read", flag_byte, 8'h40);
        flag_rd = 1; upd_done = 1; step(); clear_strobes();
        check(flag_byte == 8'h10, "R9 update kept over read", flag_byte, 8'h10);

        // enable raised on a pending flag
        ctrl_en = 3'b001; step();
        check(flag_byte[7] == 1'b1 && !irq_n, "R7 late enable", flag_byte[7], 1);
        flag_rd = 1; step(); clear_strobes();

        // random traffic against the model
        for (int k = 0; k < 2000; k++) begin
            cur_sec  = 8'($urandom_range(0, 3));
            cur_min  = 8'($urandom_range(0, 3));
            cur_hour = 8'($urandom_range(0, 3));
            alm_sec  = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(8'hC0, 8'hFF)) : 8'($urandom_range(0, 3));
            alm_min  = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(8'hC0, 8'hFF)) : 8'($urandom_range(0, 3));
            alm_hour = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(8'hC0, 8'hFF)) : 8'($urandom_range(0, 3));
            upd_done = ($urandom_range(0, 4) == 0);
            per_tick = ($urandom_range(0, 5) == 0);
            flag_rd  = ($urandom_range(0, 6) == 0);
            if ($urandom_range(0, 15) == 0) ctrl_en = 3'($urandom_range(0, 7));
            step();
        end
        clear_strobes();
        step(); step();
        finish_run();
    end
endmodule